// File: doc/BRIEF.md
# Cycle-Bit Descriptor Ring Producer

This block owns the producer side of a circular ring of 128-bit descriptors held in an on-chip single-port RAM. Each descriptor carries a cycle bit, and ownership passes to the consumer when that bit matches the consumer's expected phase. The highest slot of the ring is permanently a link entry that sends the consumer back to slot zero. That slot is never counted as free space and never carries data.

Software-side logic drives one operation at a time over a valid/ready handshake. Seven operations exist: reinitialise the ring, test whether K descriptors fit, stage a descriptor at an offset from the head, commit K staged descriptors, discard all outstanding entries, put a single descriptor, and read back any slot. Commits flip the first descriptor's cycle bit only after the head has moved and the link entry has been updated. A batch therefore appears to the consumer all at once. The consumer's progress arrives through a separate tail load input. Head, tail and producer cycle state are visible at all times.

Top module: `ring_producer`

## Requirements
- R1: After rst_ni deasserts, or after an accepted reset operation (op_i=0), op_ready_o stays low for exactly DEPTH cycles while every slot is cleared to zero. The link slot is the exception. Afterwards head_o=0, tail_o=0 and cycle_o=1.
- R2: The link slot, index DEPTH-1, holds RING_BASE in bits [63:0], the value 6 in bits [111:106] and 1 in the toggle flag bit 97. All other bits are 0 after initialisation, including the cycle bit 96 and the chain bit 100.
- R3: The head advances modulo DEPTH-1, so it never equals DEPTH-1. Every commit whose advance passes the link slot inverts cycle_o. Other operations leave cycle_o unchanged, except reset, which sets it to 1.
- R4: A space operation (op_i=1) with count K returns space_ok_o=1 when the head can step K times without landing on the tail. Each step wraps from DEPTH-2 to 0. K=0 returns 0. The result comes with resp_valid_o one cycle after acceptance.
- R5: A write operation (op_i=2) with offset k stores op_desc_i in slot (head+k) mod (DEPTH-1). Bit 96 is replaced by cycle_o, inverted once if head+k reaches DEPTH-1, and inverted once more when op_publish_i=0.
- R6: A commit that wraps rewrites the link slot. Its chain bit 100 becomes equal to bit 100 of slot DEPTH-2, and its cycle bit 96 is inverted.
- R7: A commit operation (op_i=3) of count K moves the head K steps. After that, it inverts bit 96 of the slot at the old head. op_ready_o is low for 2 cycles after acceptance, or 3 cycles if the commit wraps.
- R8: A skip operation (op_i=4) sets tail_o to head_o and leaves cycle_o unchanged, so the ring reads as empty.
- R9: A put operation (op_i=5) has the same effect as a write at offset 0 with op_publish_i=0 followed by a commit of 1.
- R10: When tail_load_i is high, tail_o takes tail_idx_i on the next edge. A skip accepted in the same cycle is overridden, and a reset operation accepted in the same cycle takes precedence.
- R11: A peek operation (op_i=6) with index op_count_i returns that slot's full contents on resp_desc_o, with resp_valid_o high one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Operation request |
| op_ready_o | output | 1 | Block can accept an operation |
| op_i | input | 3 | Operation code |
| op_count_i | input | IDX_W | Count K, write offset, or peek index |
| op_publish_i | input | 1 | Write stores the publishing cycle value |
| op_desc_i | input | 128 | Descriptor for write and put |
| tail_load_i | input | 1 | Load the tail pointer |
| tail_idx_i | input | IDX_W | New tail value |
| resp_valid_o | output | 1 | Space or peek result valid |
| resp_desc_o | output | 128 | Peeked slot contents |
| space_ok_o | output | 1 | Result of the last space check |
| head_o | output | IDX_W | Head index |
| tail_o | output | IDX_W | Tail index |
| cycle_o | output | 1 | Producer cycle state |

## Verification
The checks assume that every index the block receives is below DEPTH-1: tail_idx_i, write offsets, and commit and space counts. They also assume that commit counts are non-zero. The bench builds its stimulus from a model's head and tail, so these limits hold throughout. The model pulls the tail up to the head often enough that staged batches stay below the ring's usable size. The properties also rely on op_valid_i being sampled only while op_ready_o is high. The bench meets this by waiting for ready before it drives a request.

// File: rtl/ring_prod_pkg.sv
package ring_prod_pkg;
  localparam int DESC_W    = 128;
  localparam int CYCLE_BIT = 96;
  localparam int TGL_BIT   = 97;
  localparam int CHAIN_BIT = 100;
  localparam int TYPE_LSB  = 106;
  localparam int TYPE_W    = 6;
  localparam logic [TYPE_W-1:0] LINK_TYPE = 6'd6;

  typedef enum logic [2:0] {
    OP_RESET  = 3'd0,
    OP_SPACE  = 3'd1,
    OP_WRITE  = 3'd2,
    OP_COMMIT = 3'd3,
    OP_SKIP   = 3'd4,
    OP_PUT    = 3'd5,
    OP_PEEK   = 3'd6
  } op_e;
endpackage

// File: rtl/ring_mem.sv
module ring_mem #(
  parameter int DEPTH = 256,
  parameter int W     = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_o       <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/ring_idx_math.sv
module ring_idx_math #(
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0] base_i,
  input  logic [IDX_W-1:0] off_i,
  output logic [IDX_W-1:0] slot_o,
  output logic             wrap_o
);
  localparam logic [IDX_W:0] USED = (IDX_W+1)'(DEPTH-1);
  logic [IDX_W:0] sum;

  always_comb begin
    sum    = {1'b0, base_i} + {1'b0, off_i};
    wrap_o = (sum >= USED);
    slot_o = wrap_o ? IDX_W'(sum - USED) : IDX_W'(sum);
  end
endmodule

// File: rtl/ring_space.sv
module ring_space #(
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0] head_i,
  input  logic [IDX_W-1:0] tail_i,
  input  logic [IDX_W-1:0] cnt_i,
  output logic             ok_o
);
  localparam logic [IDX_W:0] USED = (IDX_W+1)'(DEPTH-1);
  logic [IDX_W:0] fill, need;

  always_comb begin
    fill = (head_i >= tail_i) ? ({1'b0, head_i} - {1'b0, tail_i})
                              : ({1'b0, head_i} + USED - {1'b0, tail_i});
    need = fill + {1'b0, cnt_i};
    ok_o = (cnt_i != '0) && (need < USED);
  end
endmodule

// File: rtl/ring_producer.sv
module ring_producer
  import ring_prod_pkg::*;
#(
  parameter int          DEPTH     = 256,
  parameter logic [63:0] RING_BASE = 64'h0000_0000_8000_0000,
  localparam int         IDX_W     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  output logic              op_ready_o,
  input  logic [2:0]        op_i,
  input  logic [IDX_W-1:0]  op_count_i,
  input  logic              op_publish_i,
  input  logic [DESC_W-1:0] op_desc_i,
  input  logic              tail_load_i,
  input  logic [IDX_W-1:0]  tail_idx_i,
  output logic              resp_valid_o,
  output logic [DESC_W-1:0] resp_desc_o,
  output logic              space_ok_o,
  output logic [IDX_W-1:0]  head_o,
  output logic [IDX_W-1:0]  tail_o,
  output logic              cycle_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH-1);
  localparam logic [IDX_W-1:0] PREV = IDX_W'(DEPTH-2);

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_LINK, S_RD, S_WR} st_e;

  st_e              state_q;
  logic [IDX_W-1:0] init_idx_q, head_q, tail_q, old_head_q;
  logic             pcs_q, link_cyc_q, prev_chain_q, resp_q, space_q;

  logic             accept;
  logic [IDX_W-1:0] math_off, math_slot;
  logic             math_wrap, space_ok;
  logic             mem_en, mem_we;
  logic [IDX_W-1:0] mem_addr;
  logic [DESC_W-1:0] mem_wdata, mem_rdata;

  function automatic logic [DESC_W-1:0] link_word(input logic cyc, input logic chain);
    logic [DESC_W-1:0] w;
    w = '0;
    w[63:0] = RING_BASE;
    w[TYPE_LSB +: TYPE_W] = LINK_TYPE;
    w[TGL_BIT]   = 1'b1;
    w[CYCLE_BIT] = cyc;
    w[CHAIN_BIT] = chain;
    return w;
  endfunction

  function automatic logic [DESC_W-1:0] with_cyc(input logic [DESC_W-1:0] d, input logic c);
    logic [DESC_W-1:0] w;
    w = d;
    w[CYCLE_BIT] = c;
    return w;
  endfunction

  assign accept   = op_valid_i && (state_q == S_IDLE);
  assign math_off = (op_i == OP_PUT) ? IDX_W'(1) : op_count_i;

  ring_idx_math #(.DEPTH(DEPTH)) u_math (
    .base_i(head_q), .off_i(math_off), .slot_o(math_slot), .wrap_o(math_wrap)
  );

  ring_space #(.DEPTH(DEPTH)) u_space (
    .head_i(head_q), .tail_i(tail_q), .cnt_i(op_count_i), .ok_o(space_ok)
  );

  ring_mem #(.DEPTH(DEPTH), .W(DESC_W)) u_mem (
    .clk_i(clk_i), .en_i(mem_en), .we_i(mem_we), .addr_i(mem_addr),
    .wdata_i(mem_wdata), .rdata_o(mem_rdata)
  );

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      S_INIT: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = init_idx_q;
        mem_wdata = (init_idx_q == LAST) ? link_word(1'b0, 1'b0) : '0;
      end
      S_IDLE: begin
        if (op_valid_i) begin
          unique case (op_i)
            OP_WRITE: begin
              mem_en    = 1'b1;
              mem_we    = 1'b1;
              mem_addr  = math_slot;
              mem_wdata = with_cyc(op_desc_i, pcs_q ^ math_wrap ^ ~op_publish_i);
            end
            OP_PUT: begin
              mem_en    = 1'b1;
              mem_we    = 1'b1;
              mem_addr  = head_q;
              mem_wdata = with_cyc(op_desc_i, ~pcs_q);
            end
            OP_PEEK: begin
              mem_en   = 1'b1;
              mem_addr = op_count_i;
            end
            default: ;
          endcase
        end
      end
      S_LINK: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = LAST;
        mem_wdata = link_word(link_cyc_q, prev_chain_q);
      end
      S_RD: begin
        mem_en   = 1'b1;
        mem_addr = old_head_q;
      end
      S_WR: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = old_head_q;
        mem_wdata = with_cyc(mem_rdata, ~mem_rdata[CYCLE_BIT]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_INIT;
      init_idx_q   <= '0;
      head_q       <= '0;
      tail_q       <= '0;
      old_head_q   <= '0;
      pcs_q        <= 1'b1;
      link_cyc_q   <= 1'b0;
      prev_chain_q <= 1'b0;
      resp_q       <= 1'b0;
      space_q      <= 1'b0;
    end else begin
      resp_q <= accept && (op_i == OP_SPACE || op_i == OP_PEEK);
      if (accept && op_i == OP_SPACE) space_q <= space_ok;
      if (mem_we && mem_addr == PREV) prev_chain_q <= mem_wdata[CHAIN_BIT];

      if (accept && op_i == OP_RESET)      tail_q <= '0;
      else if (tail_load_i)                tail_q <= tail_idx_i;
      else if (accept && op_i == OP_SKIP)  tail_q <= head_q;

      unique case (state_q)
        S_INIT: begin
          init_idx_q <= init_idx_q + 1'b1;
          if (init_idx_q == LAST) state_q <= S_IDLE;
        end
        S_IDLE: begin
          if (op_valid_i) begin
            if (op_i == OP_RESET) begin
              state_q    <= S_INIT;
              init_idx_q <= '0;
              head_q     <= '0;
              pcs_q      <= 1'b1;
              link_cyc_q <= 1'b0;
            end else if (op_i == OP_COMMIT || op_i == OP_PUT) begin
              old_head_q <= head_q;
              head_q     <= math_slot;
              if (math_wrap) begin
                pcs_q      <= ~pcs_q;
                link_cyc_q <= ~link_cyc_q;
                state_q    <= S_LINK;
              end else begin
                state_q <= S_RD;
              end
            end
          end
        end
        S_LINK:  state_q <= S_RD;
        S_RD:    state_q <= S_WR;
        S_WR:    state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign op_ready_o   = (state_q == S_IDLE);
  assign resp_valid_o = resp_q;
  assign resp_desc_o  = mem_rdata;
  assign space_ok_o   = space_q;
  assign head_o       = head_q;
  assign tail_o       = tail_q;
  assign cycle_o      = pcs_q;
endmodule

// File: rtl/ring_producer_chk.sv
module ring_producer_chk
  import ring_prod_pkg::*;
#(
  parameter int  DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             op_valid_i,
  input logic             op_ready_o,
  input logic [2:0]       op_i,
  input logic [IDX_W-1:0] op_count_i,
  input logic             tail_load_i,
  input logic [IDX_W-1:0] tail_idx_i,
  input logic             resp_valid_o,
  input logic             space_ok_o,
  input logic [IDX_W-1:0] head_o,
  input logic [IDX_W-1:0] tail_o,
  input logic             cycle_o
);
  logic acc;
  assign acc = op_valid_i && op_ready_o;

  assert_head_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(head_o) < DEPTH - 1);

  assert_cycle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc && (op_i == OP_COMMIT || op_i == OP_PUT || op_i == OP_RESET))
    |=> cycle_o == $past(cycle_o));

  assert_reset_op_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_i == OP_RESET |=> head_o == '0 && tail_o == '0 && cycle_o && !op_ready_o);

  assert_space_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_i == OP_SPACE && op_count_i == '0 |=> resp_valid_o && !space_ok_o);

  assert_commit_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && (op_i == OP_COMMIT || op_i == OP_PUT) |=> !op_ready_o);

  assert_skip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_i == OP_SKIP && !tail_load_i |=> tail_o == $past(head_o) && cycle_o == $past(cycle_o));

  assert_tail_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_load_i && !(acc && op_i == OP_RESET) |=> tail_o == $past(tail_idx_i));

  assert_resp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(acc && (op_i == OP_PEEK || op_i == OP_SPACE)));
endmodule

bind ring_producer ring_producer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_ready_o(op_ready_o),
  .op_i(op_i), .op_count_i(op_count_i), .tail_load_i(tail_load_i), .tail_idx_i(tail_idx_i),
  .resp_valid_o(resp_valid_o), .space_ok_o(space_ok_o), .head_o(head_o),
  .tail_o(tail_o), .cycle_o(cycle_o)
);

// File: tb/ring_producer_bench.sv
`timescale 1ns/1ps
module ring_producer_bench;
  import ring_prod_pkg::*;
  localparam int DEPTH = 8;
  localparam int IDX_W = 3;
  localparam int USED  = DEPTH - 1;
  localparam logic [63:0] BASE = 64'h0000_0001_2340_0000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic op_valid = 1'b0, op_publish = 1'b0, tail_load = 1'b0;
  logic [2:0] op = 3'd0;
  logic [IDX_W-1:0] op_count = '0, tail_idx = '0;
  logic [127:0] op_desc = '0;
  logic op_ready, resp_valid, space_ok, cycle;
  logic [127:0] resp_desc;
  logic [IDX_W-1:0] head, tail;

  int checks = 0, failures = 0;
  logic [127:0] model [DEPTH];
  int m_head, m_tail;
  logic m_pcs;

  always #2 clk = ~clk;

  ring_producer #(.DEPTH(DEPTH), .RING_BASE(BASE)) u_ring_producer (
    .clk_i(clk), .rst_ni(rst_ni), .op_valid_i(op_valid), .op_ready_o(op_ready),
    .op_i(op), .op_count_i(op_count), .op_publish_i(op_publish), .op_desc_i(op_desc),
    .tail_load_i(tail_load), .tail_idx_i(tail_idx), .resp_valid_o(resp_valid),
    .resp_desc_o(resp_desc), .space_ok_o(space_ok), .head_o(head), .tail_o(tail),
    .cycle_o(cycle)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_init();
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    model[DEPTH-1][63:0]    = BASE;
    model[DEPTH-1][111:106] = 6'd6;
    model[DEPTH-1][97]      = 1'b1;
    m_head = 0; m_tail = 0; m_pcs = 1'b1;
  endtask

  task automatic model_write(input int k, input logic [127:0] d, input logic pub);
    int s; logic c;
    s = m_head + k;
    c = m_pcs;
    if (s >= USED) begin s -= USED; c = ~c; end
    if (!pub) c = ~c;
    model[s] = d;
    model[s][96] = c;
  endtask

  task automatic model_commit(input int n);
    int oh;
    oh = m_head;
    for (int i = 0; i < n; i++) begin
      m_head++;
      if (m_head == USED) begin
        m_head = 0;
        model[DEPTH-1][100] = model[DEPTH-2][100];
        model[DEPTH-1][96]  = ~model[DEPTH-1][96];
        m_pcs = ~m_pcs;
      end
    end
    model[oh][96] = ~model[oh][96];
  endtask

  function automatic logic model_space(input int n);
    int h;
    if (n == 0) return 1'b0;
    h = m_head;
    for (int i = 0; i < n; i++) begin
      h++;
      if (h == USED) h = 0;
      if (h == m_tail) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [127:0] mkdesc(input int i);
    logic [127:0] d;
    d = {32'hD000_0000 ^ 32'(i * 37), 32'(i * 1013 + 11), 32'hCAFE_0000 | 32'(i), 32'(i * 97 + 5)};
    d[100] = i[0];
    return d;
  endfunction

  task automatic send(input logic [2:0] o, input int cnt, input logic pub,
                      input logic [127:0] d, input logic tl, input int tv);
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op = o; op_count = IDX_W'(cnt); op_publish = pub; op_desc = d;
    tail_load = tl; tail_idx = IDX_W'(tv); op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; tail_load = 1'b0;
  endtask

  task automatic wait_ready();
    while (!op_ready) @(negedge clk);
  endtask

  task automatic chk_state(input string tag);
    wait_ready();
    chk({tag, " head"}, 128'(head), 128'(m_head));
    chk({tag, " tail"}, 128'(tail), 128'(m_tail));
    chk({tag, " cycle"}, 128'(cycle), 128'(m_pcs));
  endtask

  task automatic peek_chk(input string tag, input int i);
    send(OP_PEEK, i, 1'b0, '0, 1'b0, 0);
    chk({tag, " resp_valid"}, 128'(resp_valid), 128'(1));
    chk($sformatf("%s slot%0d", tag, i), resp_desc, model[i]);
  endtask

  task automatic peek_all(input string tag);
    for (int i = 0; i < DEPTH; i++) peek_chk(tag, i);
  endtask

  task automatic space_chk(input string tag, input int n);
    send(OP_SPACE, n, 1'b0, '0, 1'b0, 0);
    chk($sformatf("%s valid K=%0d", tag, n), 128'(resp_valid), 128'(1));
    chk($sformatf("%s K=%0d h=%0d t=%0d", tag, n, m_head, m_tail), 128'(space_ok), 128'(model_space(n)));
  endtask

  task automatic load_tail(input int v);
    @(negedge clk);
    tail_load = 1'b1; tail_idx = IDX_W'(v);
    @(negedge clk);
    tail_load = 1'b0;
    m_tail = v;
    chk("R10 tail load", 128'(tail), 128'(v));
  endtask

  task automatic do_put(input logic [127:0] d);
    int oh;
    oh = m_head;
    send(OP_PUT, 0, 1'b0, d, 1'b0, 0);
    model_write(0, d, 1'b0);
    model_commit(1);
    chk_state("R9 put");
    peek_chk("R9 put", oh);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    model_init();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    n = 0;
    while (!op_ready) begin @(negedge clk); n++; end
    chk("R1 init busy cycles", 128'(n), 128'(DEPTH));
    chk_state("R1 after reset");
    peek_all("R1 R2 cleared ring");

    // R3 R9: single puts across several wraps
    for (int i = 0; i < 16; i++) begin
      space_chk("R4 before put", 1);
      do_put(mkdesc(i));
      if (i % 3 == 2) load_tail(m_head);
    end
    peek_all("R3 R6 after puts");

    // R5 R6 R7: staged batches of different sizes
    for (int b = 0; b < 9; b++) begin
      int k;
      k = 1 + (b % 5);
      load_tail(m_head);
      for (int j = 0; j < DEPTH; j++) space_chk("R4 empty", j);
      for (int j = 0; j < k; j++) begin
        send(OP_WRITE, j, j != 0, mkdesc(100 + b * 8 + j), 1'b0, 0);
        model_write(j, mkdesc(100 + b * 8 + j), j != 0);
      end
      peek_all("R5 staged");
      send(OP_COMMIT, k, 1'b0, '0, 1'b0, 0);
      model_commit(k);
      chk_state("R7 commit");
      peek_all("R6 R7 committed");
      for (int j = 0; j < DEPTH; j++) space_chk("R4 partial", j);
    end

    // R8: skip empties ring, cycle unchanged
    do_put(mkdesc(200));
    do_put(mkdesc(201));
    send(OP_SKIP, 0, 1'b0, '0, 1'b0, 0);
    m_tail = m_head;
    chk_state("R8 skip");
    space_chk("R8 empty after skip", USED - 1);

    // R10: tail load beats a same-cycle skip
    do_put(mkdesc(202));
    send(OP_SKIP, 0, 1'b0, '0, 1'b1, 2);
    m_tail = 2;
    chk_state("R10 load over skip");

    // R1: reset operation while ring is in use
    do_put(mkdesc(203));
    send(OP_RESET, 0, 1'b0, '0, 1'b0, 0);
    chk("R1 busy after reset op", 128'(op_ready), 128'(0));
    model_init();
    chk_state("R1 reset op");
    peek_all("R1 R2 reset op ring");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule